// File: doc/BRIEF.md
# Fractional-N Main Divider

This block divides its own clock by an integer ratio N or by N+1, and picks one of the two anew for every output period. A small fractional accumulator makes the choice. Every time the divider finishes a count, the accumulator adds a numerator NF and wraps at a modulus Q. Q is 5 or 8, set by one select bit. When the addition wraps, the following period is one clock longer. Over Q periods the ratio therefore averages N + NF/Q.

The block has two outputs. The first is a single-clock pulse for a phase comparator, raised once per divider period. The second is the live accumulator value, which an external phase-ripple compensation stage uses, because the phase error of the pulse tracks that value.

New settings are presented with a one-cycle load strobe. They are held pending and only take over at the next period boundary, so a count in progress is never disturbed. Reset is asynchronous and active low. It clears the accumulator and the pending settings and restarts the count with the reset-default ratio. All logic runs in the input clock domain.

Top module: `frac_main_div`

## Requirements
- R1: While rst_ni is low, pulse_o is 0 and acc_o is 0. After release the defaults apply until the first boundary: N = RST_N, NF = 0, Q = 5. The first pulse_o is high RST_N-1 rising edges after the release.
- R2: pulse_o is high for exactly one clock at the end of each divider period. The pulse of one period is never followed directly by another pulse.
- R3: At the clock edge that ends a pulse_o cycle, acc_o becomes (acc + NF) mod Q. The new value is visible from the next cycle onward.
- R4: mod8_i = 0 selects Q = 5, and mod8_i = 1 selects Q = 8.
- R5: A period that follows a boundary where the accumulator wrapped lasts N+1 clocks; any other period lasts N clocks. With settings held constant, any Q consecutive periods total Q*N + NF clocks.
- R6: A loaded ratio is limited to the range 512 to 65536 inclusive. Values below 512 act as 512, and values above 65536 act as 65536.
- R7: A loaded NF at or above the selected Q acts as Q-1.
- R8: A strobe on load_i captures ratio_i, frac_i and mod8_i. The captured values take effect at the next period boundary, and the period in progress keeps its length. A strobe in the same cycle as a pulse_o takes effect at that boundary.
- R9: If the stored accumulator value is not below the Q in force at a boundary (after a change from Q = 8 to Q = 5), it is first limited to Q-1 and NF is then added.
- R10: acc_o holds its value in every cycle that does not end a pulse_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 17 | Integer ratio N to load |
| frac_i | input | 3 | Fractional numerator NF to load |
| mod8_i | input | 1 | Modulus select: 0 for Q=5, 1 for Q=8 |
| load_i | input | 1 | One-cycle strobe that captures the three settings |
| pulse_o | output | 1 | One-clock pulse at the end of each divider period |
| acc_o | output | 3 | Current fractional accumulator value |

## Verification
The bench loads settings in the middle of a period, so a design that applied them at once would shorten or stretch the running period. It also loads in the exact pulse cycle, so a design without forwarding would lose a whole period of the new setting. An out-of-range ratio and numerator check the limits: one 65536-clock period proves the upper limit, and an off-by-one in the carry handling would shift the Q-period totals. A change from Q = 8 to Q = 5 with an accumulator holding 7 shows whether the held value is limited before the add; without that limit the accumulator would leave its range.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned FD_NW = 17;
  localparam int unsigned FD_FW = 3;
  localparam int unsigned Q_LO  = 5;
  localparam int unsigned Q_HI  = 8;

  typedef struct packed {
    logic [FD_NW-1:0] n;
    logic [FD_FW-1:0] nf;
    logic             mod8;
  } fd_cfg_t;

  function automatic logic [FD_FW:0] fd_q(input logic mod8);
    return mod8 ? (FD_FW+1)'(Q_HI) : (FD_FW+1)'(Q_LO);
  endfunction
endpackage

// File: rtl/fd_settings.sv
module fd_settings
  import frac_div_pkg::*;
#(
  parameter int unsigned N_MIN = 512,
  parameter int unsigned N_MAX = 65536,
  parameter int unsigned RST_N = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [FD_NW-1:0] n_i,
  input  logic [FD_FW-1:0] nf_i,
  input  logic             mod8_i,
  output fd_cfg_t          cfg_o
);
  localparam logic [FD_NW-1:0] N_LO  = FD_NW'(N_MIN);
  localparam logic [FD_NW-1:0] N_HI  = FD_NW'(N_MAX);
  localparam logic [FD_NW-1:0] N_DEF = FD_NW'(RST_N);

  logic [FD_FW:0] q_in;
  fd_cfg_t        cfg_in, pend_q;

  always_comb begin
    q_in        = fd_q(mod8_i);
    cfg_in.mod8 = mod8_i;
    if (n_i < N_LO)       cfg_in.n = N_LO;
    else if (n_i > N_HI)  cfg_in.n = N_HI;
    else                  cfg_in.n = n_i;
    if ({1'b0, nf_i} >= q_in) cfg_in.nf = FD_FW'(q_in - 1'b1);
    else                      cfg_in.nf = nf_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q.n    <= N_DEF;
      pend_q.nf   <= '0;
      pend_q.mod8 <= 1'b0;
    end else if (load_i) begin
      pend_q <= cfg_in;
    end
  end

  // forward a strobe that lands on the boundary cycle
  assign cfg_o = load_i ? cfg_in : pend_q;

  a_r7_nf_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cfg_o.nf} < fd_q(cfg_o.mod8)));
  a_r6_n_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o.n >= N_LO) && (cfg_o.n <= N_HI));
endmodule

// File: rtl/fd_accum.sv
module fd_accum
  import frac_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [FD_FW-1:0] nf_i,
  input  logic             mod8_i,
  output logic [FD_FW-1:0] acc_o,
  output logic             carry_o
);
  logic [FD_FW-1:0] acc_q, acc_d;
  logic [FD_FW:0]   q, a_eff, sum;

  always_comb begin
    q = fd_q(mod8_i);
    // held value may exceed a freshly shrunk modulus
    a_eff   = ({1'b0, acc_q} >= q) ? (q - 1'b1) : {1'b0, acc_q};
    sum     = a_eff + {1'b0, nf_i};
    carry_o = (sum >= q);
    acc_d   = carry_o ? FD_FW'(sum - q) : FD_FW'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  a_r3_acc_below_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ({1'b0, acc_q} < $past(q)));
  a_r10_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(acc_q));
endmodule

// File: rtl/fd_counter.sv
module fd_counter
  import frac_div_pkg::*;
#(
  parameter int unsigned N_MIN = 512,
  parameter int unsigned N_MAX = 65536,
  parameter int unsigned RST_N = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FD_NW-1:0] n_i,
  input  logic             carry_i,
  output logic             tc_o
);
  localparam logic [FD_NW-1:0] N_LO    = FD_NW'(N_MIN);
  localparam logic [FD_NW-1:0] N_HI    = FD_NW'(N_MAX);
  localparam logic [FD_NW-1:0] CNT_RST = FD_NW'(RST_N - 1);

  logic [FD_NW-1:0] cnt_q;

  assign tc_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= CNT_RST;
    else if (tc_o) cnt_q <= carry_i ? n_i : (n_i - 1'b1);
    else           cnt_q <= cnt_q - 1'b1;
  end

  a_r5_reload_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> (cnt_q >= (N_LO - 1'b1)) && (cnt_q <= N_HI));
  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_o |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/frac_main_div.sv
module frac_main_div
  import frac_div_pkg::*;
#(
  parameter int unsigned N_MIN = 512,
  parameter int unsigned N_MAX = 65536,
  parameter int unsigned RST_N = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FD_NW-1:0] ratio_i,
  input  logic [FD_FW-1:0] frac_i,
  input  logic             mod8_i,
  input  logic             load_i,
  output logic             pulse_o,
  output logic [FD_FW-1:0] acc_o
);
  fd_cfg_t cfg;
  logic    tc, carry;

  fd_settings #(.N_MIN(N_MIN), .N_MAX(N_MAX), .RST_N(RST_N)) u_set (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .n_i    (ratio_i),
    .nf_i   (frac_i),
    .mod8_i (mod8_i),
    .cfg_o  (cfg)
  );

  fd_accum u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tc),
    .nf_i    (cfg.nf),
    .mod8_i  (cfg.mod8),
    .acc_o   (acc_o),
    .carry_o (carry)
  );

  fd_counter #(.N_MIN(N_MIN), .N_MAX(N_MAX), .RST_N(RST_N)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .n_i     (cfg.n),
    .carry_i (carry),
    .tc_o    (tc)
  );

  assign pulse_o = tc;

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: tb/frac_main_div_test.sv
module frac_main_div_test;
  localparam int CLK_PERIOD = 10;
  localparam int RST_N      = 512;
  localparam int WD_LIMIT   = 190000;
  localparam int NVEC       = 9;
  // ratio, numerator, mod8, expected total of Q periods
  localparam int VEC [NVEC][4] = '{
    '{512, 0, 0, 2560},
    '{512, 1, 0, 2561},
    '{515, 3, 1, 4123},
    '{600, 4, 0, 3004},
    '{520, 7, 1, 4167},
    '{512, 6, 0, 2564},
    '{100, 2, 0, 2562},
    '{513, 5, 1, 4109},
    '{514, 2, 0, 2572}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [16:0] ratio_i = '0;
  logic [2:0]  frac_i = '0;
  logic        mod8_i = 1'b0;
  logic        load_i = 1'b0;
  logic        pulse_o;
  logic [2:0]  acc_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_main_div uut (
    .clk_i(clk), .rst_ni(rst_ni), .ratio_i(ratio_i), .frac_i(frac_i),
    .mod8_i(mod8_i), .load_i(load_i), .pulse_o(pulse_o), .acc_o(acc_o)
  );

  int n_chk = 0, n_bad = 0;
  int m_n = RST_N, m_nf = 0, m_q = 5, m_acc = 0;
  int exp_len = RST_N - 1, since = 0, last_len = 0, pulses = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampn(input int n);
    if (n < 512) return 512;
    if (n > 65536) return 65536;
    return n;
  endfunction

  task automatic do_load(input int n, input int nf, input bit m8);
    ratio_i = 17'(n);
    frac_i  = 3'(nf);
    mod8_i  = m8;
    load_i  = 1'b1;
    m_n  = clampn(n);
    m_q  = m8 ? 8 : 5;
    m_nf = (nf >= m_q) ? m_q - 1 : nf;
  endtask

  // evaluate at the current falling edge, then advance one clock
  task automatic tick();
    since++;
    check("R10 acc_o value", int'(acc_o), m_acc);
    if (pulse_o) begin
      check("R2 R5 period length", since, exp_len);
      last_len = since;
      since = 0;
      pulses++;
      begin
        int a, s;
        a = (m_acc >= m_q) ? m_q - 1 : m_acc;
        s = a + m_nf;
        if (s >= m_q) begin m_acc = s - m_q; exp_len = m_n + 1; end
        else          begin m_acc = s;       exp_len = m_n;     end
      end
    end
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic wait_pulses(input int k);
    int target;
    target = pulses + k;
    while (pulses < target) tick();
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0;
    #1;
    check("R1 pulse_o in reset", int'(pulse_o), 0);
    check("R1 acc_o in reset", int'(acc_o), 0);
    m_n = RST_N; m_nf = 0; m_q = 5; m_acc = 0;
    exp_len = RST_N - 1;
    @(negedge clk);
    rst_ni = 1'b1;
    since = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    apply_reset();
    wait_pulses(1);
    check("R1 first pulse after release", last_len, RST_N - 1);

    // vector walk: Q-period totals
    for (int i = 0; i < NVEC; i++) begin
      int sum, q;
      q = VEC[i][2] ? 8 : 5;
      do_load(VEC[i][0], VEC[i][1], VEC[i][2] != 0);
      tick();
      wait_pulses(1);
      sum = 0;
      for (int k = 0; k < q; k++) begin
        wait_pulses(1);
        sum += last_len;
      end
      check($sformatf("R4 R5 R6 R7 Q-period total vec %0d", i), sum, VEC[i][3]);
    end

    // R8: strobe in the pulse cycle applies at that boundary
    while (!pulse_o) tick();
    do_load(530, 0, 0);
    tick();
    wait_pulses(1);
    check("R8 load in boundary cycle", last_len, 530);

    // R8: strobe mid-period leaves the running period alone
    repeat (100) tick();
    do_load(700, 0, 0);
    tick();
    wait_pulses(1);
    check("R8 mid-period load deferred", last_len, 530);
    wait_pulses(1);
    check("R8 new ratio after boundary", last_len, 700);

    // R6: upper ratio limit
    do_load(70000, 0, 0);
    tick();
    wait_pulses(1);
    do_load(512, 0, 0);
    tick();
    wait_pulses(1);
    check("R6 ratio limited to 65536", last_len, 65536);

    // R9: shrink modulus while accumulator holds 7
    do_load(512, 7, 1);
    tick();
    wait_pulses(1);
    for (int k = 0; k < 10; k++) begin
      if (m_acc == 7) break;
      wait_pulses(1);
    end
    check("R9 accumulator reached 7", int'(acc_o), 7);
    do_load(512, 0, 0);
    tick();
    wait_pulses(1);
    check("R9 held value limited to Q-1", int'(acc_o), 4);
    check("R3 R4 no wrap with NF 0", last_len, 512);

    // R1: reset in mid-run restores defaults
    do_load(600, 3, 1);
    tick();
    wait_pulses(2);
    repeat (37) tick();
    apply_reset();
    wait_pulses(1);
    check("R1 first pulse after second release", last_len, RST_N - 1);
    wait_pulses(2);
    check("R1 default ratio in force", last_len, RST_N);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule